// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block collects level-sensitive interrupt requests from sixteen external pins, a set of on-chip peripheral lines and one debug line. Each request takes a 4-bit level from small writable priority registers. The sixteen pins share two level fields, one for each group of eight. Each peripheral has its own field. The debug line always sits at level 15. Every cycle the block finds the highest pending level and compares it with the CPU's 4-bit mask. If the level is strictly greater than the mask, it raises an interrupt request together with that level.

When the CPU acknowledges, the block latches an event code that names the winning source. Software can use that code directly as a branch offset, since many sources share one vector. The block never alters the mask; raising the mask is software's job.

In standby, a subset of sources can raise a wake-up signal: the first pin group, the timer peripheral and the real-time-clock peripheral. This only happens when the low-speed clock option is enabled.

Top module: `irq_arbiter`

## Requirements
- R1: Register map, with an 8-bit data port and one shared address for read and write. Address 0 holds the level for pins 0–7 in bits [3:0] and the level for pins 8–15 in bits [7:4]. Address 1+k holds the level of peripheral k in bits [3:0], with k from 0 to 6, and reads 0 in bits [7:4]. Unused addresses read 0.
- R2: Address 8 is the debug source. It always reads 0x0F, and writes to it have no effect. A pending debug request competes at level 15.
- R3: A source whose level is 0 never raises a request and never raises a wake-up.
- R4: `irqOut` rises one cycle after the highest pending level is strictly greater than `cpuMask`. When it does, `irqLevel` carries that level. Otherwise `irqOut` is 0 and `irqLevel` is 0.
- R5: Ties on level are broken in a fixed order: debug first, then peripherals from index 0 upward, then pins from index 0 upward.
- R6: Requests are level-sensitive. A request that drops is no longer considered from the next cycle on.
- R7: `evtCode` equals 0x200 + 0x20·s. The source number s is 0 for debug, 1+k for peripheral k, and 8+i for pin i. The code is captured at a clock edge where `intAck` is high and a source above the mask is pending. At any other edge it holds.
- R8: Acknowledge changes nothing but `evtCode`. A request that is still held keeps `irqOut` high, and the priority registers are unchanged.
- R9: `wakeOut` goes high one cycle after `standby` and `lowSpeedEn` are both high and a pin 0–7, peripheral 0 (timer) or peripheral 1 (real-time clock) is pending at a level above the mask. Pins 8–15, other peripherals and debug never wake the chip.
- R10: After reset, all writable levels are 0, and `irqOut`, `irqLevel`, `evtCode` and `wakeOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| extReq | input | 16 | External level requests |
| perReq | input | 7 | Peripheral requests |
| dbgReq | input | 1 | Debug request, fixed level 15 |
| cpuMask | input | 4 | CPU interrupt mask level |
| standby | input | 1 | Chip is in standby |
| lowSpeedEn | input | 1 | Low-speed clock option enabled |
| intAck | input | 1 | CPU acknowledge |
| irqOut | output | 1 | Interrupt request |
| irqLevel | output | 4 | Level of the requesting source |
| evtCode | output | 12 | Latched event code of the acknowledged source |
| wakeOut | output | 1 | Standby wake-up request |

## Verification
Different kinds of wrong internal state show up at different points. A wrong priority field shows at once on `regRdData`. On `irqLevel` it shows one cycle after the affected source is asserted. A wrong winner or tie order is invisible until the next acknowledge, because only then does it reach `evtCode` one cycle later, so the bench acknowledges under several contested patterns. Wake-up qualification faults appear on `wakeOut` one cycle after `standby` is set, and only under matching source patterns, so both the wake-capable and the non-wake sources are exercised.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    logic wrExt;
    logic wrPer;
    logic latchEvt;
  } ctrlStrobe_t;

  typedef struct packed {
    logic   winAbove;
    logic   wakeHit;
    level_t winLevel;
  } dpStatus_t;
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_EXT   = 16,
  parameter int NUM_PER   = 7,
  parameter int GRP       = 8,
  parameter int WAKE_PER  = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 12,
  parameter int CODE_BASE = 'h200,
  parameter int CODE_STEP = 'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_EXT-1:0]  extReq,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic                dbgReq,
  input  level_t              cpuMask,
  output dpStatus_t           stat,
  output logic [CODE_W-1:0]   evtCode
);
  localparam int NGRP    = NUM_EXT / GRP;
  localparam int NSRC    = 1 + NUM_PER + NUM_EXT;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int EXT_OFS = 1 + NUM_PER;
  localparam int DBG_ADDR = NUM_PER + 1;
  localparam level_t TOP_LVL = '1;

  level_t grpPrio [NGRP];
  level_t perPrio [NUM_PER];
  level_t srcLvl  [NSRC];
  logic   [NSRC-1:0] wakeCand;

  // group priority fields, packed side by side at address 0
  for (genvar g = 0; g < NGRP; g++) begin : gGrp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            grpPrio[g] <= '0;
      else if (strb.wrExt)  grpPrio[g] <= regWrData[LVL_W*g +: LVL_W];
    end
  end

  for (genvar k = 0; k < NUM_PER; k++) begin : gPer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) perPrio[k] <= '0;
      else if (strb.wrPer && regAddr == ADDR_W'(1 + k))
        perPrio[k] <= regWrData[LVL_W-1:0];
    end
    assign srcLvl[1+k]   = perReq[k] ? perPrio[k] : '0;
    assign wakeCand[1+k] = (k < WAKE_PER);
  end

  assign srcLvl[0]   = dbgReq ? TOP_LVL : '0;
  assign wakeCand[0] = 1'b0;

  for (genvar i = 0; i < NUM_EXT; i++) begin : gExt
    assign srcLvl[EXT_OFS+i]   = extReq[i] ? grpPrio[i/GRP] : '0;
    assign wakeCand[EXT_OFS+i] = (i < GRP);
  end

  // winner search: scanning downward with >= lets lower source numbers win ties
  level_t            bestLvl;
  logic [IDX_W-1:0]  bestIdx;
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (srcLvl[s] != '0 && srcLvl[s] >= bestLvl) begin
        bestLvl = srcLvl[s];
        bestIdx = IDX_W'(s);
      end
    end
  end

  logic wakeAny;
  always_comb begin
    wakeAny = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (wakeCand[s] && srcLvl[s] > cpuMask) wakeAny = 1'b1;
  end

  assign stat.winAbove = bestLvl > cpuMask;
  assign stat.winLevel = bestLvl;
  assign stat.wakeHit  = wakeAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              evtCode <= '0;
    else if (strb.latchEvt) evtCode <= CODE_W'(CODE_BASE) + CODE_W'(CODE_STEP) * CODE_W'(bestIdx);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) begin
      for (int g = 0; g < NGRP; g++) regRdData[LVL_W*g +: LVL_W] = grpPrio[g];
    end else if (regAddr == ADDR_W'(DBG_ADDR)) begin
      regRdData[LVL_W-1:0] = TOP_LVL;
    end else begin
      for (int k = 0; k < NUM_PER; k++)
        if (regAddr == ADDR_W'(1 + k)) regRdData[LVL_W-1:0] = perPrio[k];
    end
  end
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
#(
  parameter int NUM_PER = 7,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              intAck,
  input  logic              standby,
  input  logic              lowSpeedEn,
  input  dpStatus_t         stat,
  output ctrlStrobe_t       strb,
  output logic              irqOut,
  output level_t            irqLevel,
  output logic              wakeOut
);
  assign strb.wrExt    = regWrEn && regAddr == '0;
  assign strb.wrPer    = regWrEn && regAddr != '0 && regAddr <= ADDR_W'(NUM_PER);
  assign strb.latchEvt = intAck && stat.winAbove;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      irqLevel <= '0;
      wakeOut  <= 1'b0;
    end else begin
      irqOut   <= stat.winAbove;
      irqLevel <= stat.winAbove ? stat.winLevel : '0;
      wakeOut  <= standby && lowSpeedEn && stat.wakeHit;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_EXT = 16,
  parameter int NUM_PER = 7,
  parameter int GRP     = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int CODE_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [NUM_PER-1:0] perReq,
  input  logic               dbgReq,
  input  logic [3:0]         cpuMask,
  input  logic               standby,
  input  logic               lowSpeedEn,
  input  logic               intAck,
  output logic               irqOut,
  output logic [3:0]         irqLevel,
  output logic [CODE_W-1:0]  evtCode,
  output logic               wakeOut
);
  ctrlStrobe_t strb;
  dpStatus_t   stat;

  irq_arb_datapath #(
    .NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER), .GRP(GRP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extReq(extReq),
    .perReq(perReq), .dbgReq(dbgReq), .cpuMask(cpuMask),
    .stat(stat), .evtCode(evtCode)
  );

  irq_arb_control #(.NUM_PER(NUM_PER), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .intAck(intAck), .standby(standby), .lowSpeedEn(lowSpeedEn),
    .stat(stat), .strb(strb), .irqOut(irqOut), .irqLevel(irqLevel),
    .wakeOut(wakeOut)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              dbgReq,
  input logic [3:0]        cpuMask,
  input logic              standby,
  input logic              lowSpeedEn,
  input logic              intAck,
  input logic              irqOut,
  input logic [3:0]        irqLevel,
  input logic [CODE_W-1:0] evtCode,
  input logic              wakeOut
);
  // R4
  irq_above_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqLevel > $past(cpuMask));

  // R4
  idle_level_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> irqLevel == 4'd0);

  // R2
  debug_top_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgReq && cpuMask != 4'hF) |=> (irqOut && irqLevel == 4'hF));

  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> $stable(evtCode));

  // R9
  wake_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> $past(standby && lowSpeedEn));
endmodule

bind irq_arbiter irq_arb_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .cpuMask(cpuMask),
  .standby(standby), .lowSpeedEn(lowSpeedEn), .intAck(intAck),
  .irqOut(irqOut), .irqLevel(irqLevel), .evtCode(evtCode), .wakeOut(wakeOut)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic [15:0] extReq = 0;
  logic [6:0] perReq = 0;
  logic dbgReq = 0, standby = 0, lowSpeedEn = 0, intAck = 0;
  logic [3:0] cpuMask = 0;
  logic irqOut, wakeOut;
  logic [3:0] irqLevel;
  logic [11:0] evtCode;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter u_dut (.*);

  // behavioural reference
  int mGrp[2];
  int mPer[7];
  int mIrq, mLvl, mEvt, mWake;

  task automatic refPick(output int lvl, output int code, output bit wake);
    lvl = 0; code = 0; wake = 0;
    if (dbgReq) begin lvl = 15; code = 'h200; end
    for (int k = 0; k < 7; k++)
      if (perReq[k] && mPer[k] > lvl) begin lvl = mPer[k]; code = 'h220 + 'h20 * k; end
    for (int i = 0; i < 16; i++)
      if (extReq[i] && mGrp[i/8] > lvl) begin lvl = mGrp[i/8]; code = 'h300 + 'h20 * i; end
    for (int k = 0; k < 2; k++)
      if (perReq[k] && mPer[k] > int'(cpuMask)) wake = 1;
    for (int i = 0; i < 8; i++)
      if (extReq[i] && mGrp[0] > int'(cpuMask)) wake = 1;
  endtask

  always @(posedge clk or negedge rstN) begin
    int lvl, code;
    bit wk;
    if (!rstN) begin
      mGrp = '{0, 0}; mPer = '{0, 0, 0, 0, 0, 0, 0};
      mIrq = 0; mLvl = 0; mEvt = 0; mWake = 0;
    end else begin
      refPick(lvl, code, wk);
      mIrq  = (lvl > int'(cpuMask)) ? 1 : 0;
      mLvl  = mIrq ? lvl : 0;
      mWake = (standby && lowSpeedEn && wk) ? 1 : 0;
      if (intAck && mIrq) mEvt = code;
      if (regWrEn) begin
        if (regAddr == 0) begin mGrp[0] = regWrData[3:0]; mGrp[1] = regWrData[7:4]; end
        else if (regAddr >= 1 && regAddr <= 7) mPer[regAddr-1] = regWrData[3:0];
      end
    end
  end

  function automatic int refRead(int a);
    if (a == 0) return mGrp[1] * 16 + mGrp[0];
    if (a >= 1 && a <= 7) return mPer[a-1];
    if (a == 8) return 'h0F;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      chk("R4 irqOut", irqOut, mIrq);
      chk("R4 irqLevel", irqLevel, mLvl);
      chk("R7 evtCode", evtCode, mEvt);
      chk("R9 wakeOut", wakeOut, mWake);
      chk("R1 regRdData", regRdData, refRead(regAddr));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); regWrEn = 1; regAddr = 4'(a); regWrData = 8'(d);
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic ack();
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    // R10 reset state
    chk("R10 irqOut", irqOut, 0);
    chk("R10 evtCode", evtCode, 0);
    chk("R10 wakeOut", wakeOut, 0);
    chk("R10 regRdData", regRdData, 0);

    @(negedge clk); extReq[3] = 1; tick();
    chk("R3 level0 pin", irqOut, 0);

    wr(0, 'h75); tick();
    chk("R1 group read", regRdData, 'h75);
    chk("R4 level5", irqLevel, 5);

    @(negedge clk); cpuMask = 5; tick();
    chk("R4 equal mask", irqOut, 0);
    @(negedge clk); cpuMask = 4; tick();
    chk("R4 above mask", irqOut, 1);

    @(negedge clk); extReq[9] = 1; tick();
    chk("R4 group hi", irqLevel, 7);
    ack(); tick();
    chk("R7 pin9 code", evtCode, 'h420);
    chk("R8 held after ack", irqOut, 1);

    wr(3, 7);
    @(negedge clk); perReq[2] = 1; tick();
    ack(); tick();
    chk("R5 tie peripheral", evtCode, 'h260);
    chk("R8 prio kept", regRdData, 7);

    @(negedge clk); extReq[9] = 0; perReq[2] = 0; tick();
    chk("R6 withdrawn", irqLevel, 5);
    @(negedge clk); cpuMask = 6; intAck = 1; tick();
    @(negedge clk); intAck = 0; tick();
    chk("R7 no-winner hold", evtCode, 'h260);
    @(negedge clk); extReq[3] = 0; cpuMask = 4; tick();
    chk("R6 dropped", irqOut, 0);

    @(negedge clk); cpuMask = 14; dbgReq = 1; tick();
    chk("R2 debug level", irqLevel, 15);
    ack(); tick();
    chk("R2 debug code", evtCode, 'h200);
    wr(8, 3);
    @(negedge clk); regAddr = 8; tick();
    chk("R2 debug read", regRdData, 'h0F);
    @(negedge clk); cpuMask = 15; tick();
    chk("R2 mask15", irqOut, 0);
    @(negedge clk); dbgReq = 0; cpuMask = 0; regAddr = 0;

    @(negedge clk); standby = 1; lowSpeedEn = 1; extReq[2] = 1; tick();
    chk("R9 pin2 wake", wakeOut, 1);
    @(negedge clk); extReq[2] = 0; extReq[12] = 1; tick();
    chk("R9 pin12 no wake", wakeOut, 0);
    chk("R9 pin12 irq", irqOut, 1);
    @(negedge clk); lowSpeedEn = 0; extReq[2] = 1; tick();
    chk("R9 lowspeed off", wakeOut, 0);
    @(negedge clk); lowSpeedEn = 1; tick();
    chk("R9 lowspeed on", wakeOut, 1);
    wr(1, 4);
    @(negedge clk); extReq = 0; perReq[0] = 1; cpuMask = 3; tick();
    chk("R9 timer wake", wakeOut, 1);
    @(negedge clk); cpuMask = 4; tick();
    chk("R9 timer masked", wakeOut, 0);
    @(negedge clk); perReq = 0; standby = 0;
    repeat (3) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule